// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synchronous single-port word memory. Reads and writes can be issued in any mix on consecutive enabled clock edges, and one data word moves on every cycle with no idle slots. Address and control are registered at the capture edge. Read data leaves through an output register. Write data is taken two enabled edges after its address. A read therefore uses the same data-bus slot that a write issued at that edge would use, and switching between reads and writes costs no cycles.

The shared data bus is split into `wdata`, `rdata` and a driver enable `dq_oe`. The driver is turned off in every slot that does not carry read data. A clock enable freezes the whole block. Three chip selects qualify new operations, and four active-low byte selects gate the write lanes. A load/advance control runs four-beat bursts in either linear or interleaved order. The array holds 2**`AW` words: the default `AW` of 10 keeps elaboration small, and `AW` = 16 gives 65536 words of 32 bits.

Top module: `zbt_sram`

## Requirements
- R1: With `AW` = 10 the array holds 1024 words of 32 bits. Every address from 0 to 1023 stores the last word written to it and returns it on a read.
- R2: For a selected read captured at enabled edge n, `rdata` is loaded at enabled edge n+1. `dq_oe` is 1 from that edge until the next enabled edge, so the master samples the data at edge n+2.
- R3: For a selected write captured at enabled edge n, `wdata` is sampled at enabled edge n+2. A read issued at the very next edge returns that word.
- R4: Any sequence of reads, writes and deselects can be issued on consecutive enabled edges. Each read returns the data of all writes issued before it, including a write whose data arrives on the same edge as the read's data is registered.
- R5: `bw_n[i]` = 0 writes bits 8i+7..8i of the word. A lane whose select is 1 keeps its old value, and this holds for reads served from a pending write as well.
- R6: A load (`ld_n` = 0) is selected only when `sel_a_n` = 0, `sel_b` = 1 and `sel_c_n` = 0. Any other combination is a deselect: nothing is written and `dq_oe` stays 0 in its data slot.
- R7: While `cke` = 0 no input is captured, no write is committed, and `rdata` and `dq_oe` hold their values.
- R8: `dq_oe` is 0 in the data slot of every write.
- R9: `oe_n` = 1 forces `dq_oe` to 0 at once, without waiting for a clock edge.
- R10: With `burst_lin` = 1, advance beat k (k = 1, 2, 3) from base address B uses address bits [1:0] = (B[1:0] + k) mod 4. The upper bits are unchanged.
- R11: With `burst_lin` = 0, advance beat k uses address bits [1:0] = B[1:0] XOR k. The upper bits are unchanged.
- R12: An advance (`ld_n` = 1) repeats the read/write type and the select state of the last load, and ignores the chip selects and `we_n`. The fourth advance wraps back to address B.
- R13: After reset `dq_oe` = 0 and `rdata` = 0. No operation is pending, and an advance before any load is a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable, 0 stalls the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | 0 loads a new address, 1 advances the burst |
| we_n | input | 1 | 0 makes a load a write, 1 a read |
| bw_n | input | 4 | Byte lane write selects, active low |
| burst_lin | input | 1 | 1 selects linear burst order, 0 interleaved |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data, bus inbound side |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 32 | Registered read data |
| dq_oe | output | 1 | Data bus driver enable |

## Verification
The bench targets a read issued right after a write to the same word, while that write's data is still on the bus. A design without forwarding returns the stale word there, and one with the wrong byte merge corrupts lanes. It also stalls the block in the middle of pending writes and reads: a design that leaks a write through a stall, or moves `rdata`, fails the held-value checks. Bursts in both orders, including the wrap on the fourth advance and advances taken after a deselected load, catch address formation or type repetition that has gone wrong. Checks of `dq_oe` in every write and deselect slot, and during an asynchronous `oe_n` pulse, catch bus contention.

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int AW = 10,
  parameter int DW = 32,
  parameter int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke,
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          sel_c_n,
  input  logic          ld_n,
  input  logic          we_n,
  input  logic [NB-1:0] bw_n,
  input  logic          burst_lin,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          oe_n,
  output logic [DW-1:0] rdata,
  output logic          dq_oe
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic [AW-1:0] bst_base;
  logic [1:0]    bst_cnt;
  logic          bst_wr, bst_act;

  logic          s1_vld, s1_wr, s2_vld, s2_wr, rd_drv;
  logic [AW-1:0] s1_addr, s2_addr;
  logic [NB-1:0] s1_be, s2_be;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [NB-1:0] be);
    logic [DW-1:0] r;
    r = old_w;
    for (int i = 0; i < NB; i++)
      if (be[i]) r[8*i +: 8] = new_w[8*i +: 8];
    return r;
  endfunction

  wire          sel      = !sel_a_n && sel_b && !sel_c_n;
  wire [1:0]    nxt_cnt  = bst_cnt + 2'd1;
  wire [1:0]    lo_bits  = burst_lin ? bst_base[1:0] + nxt_cnt : bst_base[1:0] ^ nxt_cnt;
  wire [AW-1:0] adv_addr = {bst_base[AW-1:2], lo_bits};

  wire          op_vld  = ld_n ? bst_act  : sel;
  wire          op_wr   = ld_n ? bst_wr   : !we_n;
  wire [AW-1:0] op_addr = ld_n ? adv_addr : addr;

  wire          wr_hit = s2_vld && s2_wr && (s2_addr == s1_addr);
  wire [DW-1:0] rd_word = wr_hit ? merge(mem[s1_addr], wdata, s2_be) : mem[s1_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_wr    <= 1'b0;
      s1_addr  <= '0;
      s1_be    <= '0;
      s2_vld   <= 1'b0;
      s2_wr    <= 1'b0;
      s2_addr  <= '0;
      s2_be    <= '0;
      rd_drv   <= 1'b0;
      rdata    <= '0;
      bst_base <= '0;
      bst_cnt  <= '0;
      bst_wr   <= 1'b0;
      bst_act  <= 1'b0;
    end else if (cke) begin
      s1_vld  <= op_vld;
      s1_wr   <= op_wr;
      s1_addr <= op_addr;
      s1_be   <= ~bw_n;
      s2_vld  <= s1_vld;
      s2_wr   <= s1_wr;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
      rd_drv  <= s1_vld && !s1_wr;
      if (s1_vld && !s1_wr) rdata <= rd_word;
      if (!ld_n) begin
        bst_base <= addr;
        bst_cnt  <= 2'd0;
        bst_wr   <= !we_n;
        bst_act  <= sel;
      end else begin
        bst_cnt <= nxt_cnt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cke && s2_vld && s2_wr)
      mem[s2_addr] <= merge(mem[s2_addr], wdata, s2_be);
  end

  assign dq_oe = rd_drv && !oe_n;

  // R8
  wr_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld && s2_wr) |-> !dq_oe);

  // R2
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && s1_vld && !s1_wr) |=> rd_drv);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ($stable(rdata) && $stable(rd_drv) && $stable(s2_vld) && $stable(s1_addr)));

  // R6
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !ld_n && !sel) |=> !s1_vld);

  // R12
  burst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && ld_n) |=> ($stable(bst_base) && $stable(bst_wr) && $stable(bst_act)));
endmodule

// File: tb/test_zbt_sram.sv
module test_zbt_sram;
  localparam int AW = 10;
  localparam int MAXOP = 2048;

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b0;
  logic sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic ld_n = 1'b1, we_n = 1'b1, burst_lin = 1'b1, oe_n = 1'b0;
  logic [3:0] bw_n = 4'hf;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic dq_oe;

  zbt_sram #(.AW(AW)) i_zbt_sram (
    .clk(clk), .rst_n(rst_n), .cke(cke), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .ld_n(ld_n), .we_n(we_n), .bw_n(bw_n),
    .burst_lin(burst_lin), .addr(addr), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .dq_oe(dq_oe)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, n = 0;
  bit done = 0;

  logic [31:0] ref_mem [0:(1<<AW)-1];
  bit          ref_known [0:(1<<AW)-1];
  int          op_kind [0:MAXOP-1];
  logic [31:0] op_val [0:MAXOP-1];
  bit          op_known [0:MAXOP-1];
  string       op_tag [0:MAXOP-1];

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  bit            m_wr = 0, m_act = 0;

  function automatic logic [31:0] merge_ref(input logic [31:0] o, input logic [31:0] d,
                                            input logic [3:0] be);
    logic [31:0] r = o;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  function automatic logic [1:0] beat_lo(input logic [1:0] b, input logic [1:0] k, input bit lin);
    return lin ? b + k : b ^ k;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic service(input string over);
    int k = n - 2;
    string t;
    if (k < 0) return;
    t = (over != "") ? over : op_tag[k];
    wdata = (op_kind[k] == 2) ? op_val[k] : $urandom;
    if (op_kind[k] == 1) begin
      chk(dq_oe === 1'b1, (t == "R4") ? "R2" : t, "read drive", {31'd0, dq_oe}, 32'd1);
      if (op_known[k]) chk(rdata === op_val[k], t, "read data", rdata, op_val[k]);
      if (op_tag[k] == "R9" && over == "") begin
        oe_n = 1'b1; #1;
        chk(dq_oe === 1'b0, "R9", "oe_n gate", {31'd0, dq_oe}, 32'd0);
        oe_n = 1'b0; #1;
        chk(dq_oe === 1'b1, "R9", "oe_n release", {31'd0, dq_oe}, 32'd1);
      end
    end else begin
      chk(dq_oe === 1'b0, (op_kind[k] == 2) ? "R8" : ((t == "R4") ? "R6" : t),
          "driver off", {31'd0, dq_oe}, 32'd0);
    end
  endtask

  task automatic step(input bit ld, input bit sel, input bit wr, input logic [AW-1:0] a,
                      input logic [3:0] be, input bit lin, input string tag);
    logic [AW-1:0] ea;
    bit act, w;
    logic [31:0] d;
    @(negedge clk);
    service("");
    cke = 1'b1; ld_n = !ld; we_n = !wr; bw_n = ~be; addr = a; burst_lin = lin;
    if (sel) begin
      sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    end else begin
      case ($urandom % 3)
        0: begin sel_a_n = 1'b1; sel_b = 1'b1; sel_c_n = 1'b0; end
        1: begin sel_a_n = 1'b0; sel_b = 1'b0; sel_c_n = 1'b0; end
        default: begin sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b1; end
      endcase
    end
    if (ld) begin
      act = sel; w = wr; ea = a;
      m_base = a; m_cnt = 2'd0; m_wr = wr; m_act = sel;
    end else begin
      m_cnt = m_cnt + 2'd1;
      ea = {m_base[AW-1:2], beat_lo(m_base[1:0], m_cnt, lin)};
      act = m_act; w = m_wr;
    end
    op_tag[n] = tag;
    op_known[n] = 0;
    if (!act) op_kind[n] = 0;
    else if (w) begin
      d = $urandom;
      op_kind[n] = 2; op_val[n] = d;
      ref_mem[ea] = merge_ref(ref_mem[ea], d, be);
      if (be == 4'hf) ref_known[ea] = 1;
    end else begin
      op_kind[n] = 1; op_val[n] = ref_mem[ea]; op_known[n] = ref_known[ea];
    end
    n++;
  endtask

  task automatic stall();
    @(negedge clk);
    service("R7");
    cke = 1'b0; ld_n = $urandom; we_n = $urandom; addr = $urandom;
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0; bw_n = 4'h0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [3:0] be, input string t);
    step(1, 1, 1, a, be, 1, t);
  endtask
  task automatic rd(input logic [AW-1:0] a, input string t);
    step(1, 1, 0, a, 4'hf, 1, t);
  endtask
  task automatic adv(input bit lin, input string t);
    step(0, 1, 0, '0, 4'hf, lin, t);
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < (1 << AW); i++) begin ref_mem[i] = 'x; ref_known[i] = 0; end
    #22;
    chk(dq_oe === 1'b0, "R13", "reset drive", {31'd0, dq_oe}, 32'd0);
    chk(rdata === 32'd0, "R13", "reset rdata", rdata, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    adv(1, "R13");
    adv(1, "R13");
    for (int a = 0; a < 16; a++) wr(a[AW-1:0], 4'hf, "R1");
    wr(10'd1023, 4'hf, "R1");
    wr(10'd512, 4'hf, "R1");
    rd(10'd1023, "R1"); rd(10'd0, "R1"); rd(10'd512, "R1");

    wr(10'd5, 4'hf, "R3"); rd(10'd5, "R3");
    rd(10'd4, "R4"); wr(10'd4, 4'hf, "R4"); rd(10'd4, "R4"); wr(10'd3, 4'hf, "R4"); rd(10'd3, "R4");

    wr(10'd6, 4'b0101, "R5"); rd(10'd6, "R5");
    wr(10'd6, 4'b1000, "R5"); step(1, 0, 0, 10'd0, 4'hf, 1, "R6"); rd(10'd6, "R5");

    step(1, 0, 1, 10'd7, 4'hf, 1, "R6"); rd(10'd7, "R6");
    step(1, 0, 1, 10'd7, 4'hf, 1, "R6"); adv(1, "R6"); adv(1, "R6"); rd(10'd7, "R6");

    wr(10'd8, 4'hf, "R7"); stall(); stall(); stall(); rd(10'd8, "R7"); stall(); stall();
    rd(10'd9, "R7");

    wr(10'd9, 4'hf, "R10"); adv(1, "R10"); adv(1, "R10"); adv(1, "R10"); adv(1, "R12");
    for (int a = 8; a < 12; a++) rd(a[AW-1:0], "R10");
    rd(10'd10, "R10"); adv(1, "R10"); adv(1, "R10"); adv(1, "R10");

    wr(10'd14, 4'hf, "R11"); adv(0, "R11"); adv(0, "R11"); adv(0, "R11");
    for (int a = 12; a < 16; a++) rd(a[AW-1:0], "R11");
    rd(10'd13, "R11"); adv(0, "R11"); adv(0, "R11"); adv(0, "R11"); adv(0, "R12");
    step(1, 1, 1, 10'd1, 4'h3, 0, "R12"); step(0, 0, 0, '0, 4'hc, 0, "R12");
    step(0, 1, 0, '0, 4'hf, 0, "R12"); rd(10'd0, "R12"); rd(10'd1, "R12");

    rd(10'd2, "R9");

    for (int i = 0; i < 600; i++) begin
      if ($urandom % 10 == 0) stall();
      else step(($urandom % 10) < 7, ($urandom % 8) != 0, $urandom % 2,
                AW'($urandom % 16), ($urandom % 3 == 0) ? 4'hf : 4'($urandom),
                $urandom % 2, "R4");
    end
    step(1, 0, 0, '0, 4'hf, 1, "R6");
    step(1, 0, 0, '0, 4'hf, 1, "R6");
    step(1, 0, 0, '0, 4'hf, 1, "R6");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule